// File: doc/BRIEF.md
# Packet CRC Inserter and Checker

This block protects link-layer packets with a 16-bit CRC. Packets move as a halfword-wide stream framed by start and end markers. The first halfword is a physical header. Its top bits hold a per-hop acknowledge identifier. The transmit side passes each data halfword through one cycle later. After the last data halfword it appends a trailing CRC. When a packet carries more than forty data halfwords (80 bytes), the transmit side also inserts a mid-packet CRC after the fortieth halfword. It then pads the packet with a zero halfword when needed, so that every emitted packet is a whole number of 32-bit words.

The receive side takes a stream in the same emitted format. It runs the same CRC over every beat, and on a good packet this running value ends at zero. At the end of each packet it reports which of the two CRC positions failed.

The identifier bits are forced to zero before they enter the CRC on both sides. A later hop can therefore rewrite the identifier without recomputing the checksum.

Top module: `crc_pkt_guard`

## Requirements
- R1: The CRC uses the polynomial 0x1021 with an initial value of 0xFFFF and no final inversion. It takes each halfword most significant bit first. The trailing CRC halfword is emitted in the cycle right after the last data halfword.
- R2: In the first halfword of a packet, bits [15:11] (the identifier) are taken as zero by the CRC. They are passed to the output unchanged.
- R3: A packet with more than 40 data halfwords gets a mid CRC halfword right after data halfword 40. Its value is the CRC over data halfwords 1 to 40.
- R4: The trailing CRC continues the same running value over every data halfword and over the mid CRC halfword.
- R5: A packet of 40 or fewer data halfwords, including exactly 40, carries no mid CRC.
- R6: If data, mid CRC and trailing CRC together make an odd number of halfwords, one 0x0000 pad halfword follows the trailing CRC. tx_out_sop marks the first emitted halfword and tx_out_eop marks the last.
- R7: tx_in_ready is low in each cycle in which a CRC or pad halfword is being produced. An accepted data halfword appears on tx_out_data one cycle later.
- R8: rx_done pulses in the cycle after the receiver accepts an end-marked halfword. rx_err_pos[1] flags a trailing CRC mismatch, meaning the running CRC over all beats including any pad is not zero. rx_err_pos[0] flags a mid CRC mismatch, meaning the running value after halfword 41 is not zero; this is judged only for packets of more than 42 halfwords. rx_err is the OR of the two bits.
- R9: On receive, flipping any bits [15:11] of the first halfword does not change the result.
- R10: After reset, tx_out_valid and rx_done are low and tx_in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_in_valid | input | 1 | Transmit input halfword valid |
| tx_in_ready | output | 1 | Transmit input halfword accepted |
| tx_in_data | input | 16 | Transmit input halfword |
| tx_in_sop | input | 1 | First halfword of packet |
| tx_in_eop | input | 1 | Last data halfword of packet |
| tx_out_valid | output | 1 | Emitted halfword valid |
| tx_out_data | output | 16 | Emitted halfword |
| tx_out_sop | output | 1 | First emitted halfword |
| tx_out_eop | output | 1 | Last emitted halfword |
| rx_valid | input | 1 | Receive halfword valid |
| rx_data | input | 16 | Receive halfword |
| rx_sop | input | 1 | First received halfword |
| rx_eop | input | 1 | Last received halfword |
| rx_done | output | 1 | Check result valid |
| rx_err | output | 1 | Any CRC mismatch |
| rx_err_pos | output | 2 | bit0 mid CRC failed, bit1 trailing CRC failed |

## Verification
The checker assumes well-framed input streams. Every packet starts with a start marker and ends with one end marker, and the transmit side never sees a new start while the previous packet is still draining. The receive side is assumed to get only streams that have the emitted shape. The bench keeps to these limits by building each packet whole and then letting the output drain for several idle cycles before the next one. It sweeps every data length from 1 to 48 halfwords, which covers lengths on both sides of the 40-halfword boundary and both pad parities. On the receive side it feeds back clean copies, copies with a flipped identifier, and copies with a flipped bit before or after the mid CRC.

// File: rtl/crc_pkt_guard.sv
module crc_pkt_guard #(
  parameter int ID_W      = 5,
  parameter int ID_LSB    = 11,
  parameter int MID_BEATS = 40,
  parameter int CNT_W     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_in_valid,
  output logic        tx_in_ready,
  input  logic [15:0] tx_in_data,
  input  logic        tx_in_sop,
  input  logic        tx_in_eop,
  output logic        tx_out_valid,
  output logic [15:0] tx_out_data,
  output logic        tx_out_sop,
  output logic        tx_out_eop,
  input  logic        rx_valid,
  input  logic [15:0] rx_data,
  input  logic        rx_sop,
  input  logic        rx_eop,
  output logic        rx_done,
  output logic        rx_err,
  output logic [1:0]  rx_err_pos
);
  localparam logic [15:0] ID_MASK = 16'(((32'd1 << ID_W) - 32'd1) << ID_LSB);
  localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(MID_BEATS - 1);
  localparam logic [CNT_W-1:0] MID_POS  = CNT_W'(MID_BEATS);
  localparam logic [CNT_W-1:0] MID_MIN  = CNT_W'(MID_BEATS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  typedef enum logic [1:0] {S_DATA, S_MID, S_FIN, S_PAD} tx_st_t;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 15; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  // transmit side
  tx_st_t           tx_st;
  logic [15:0]      tx_crc;
  logic [CNT_W-1:0] tx_cnt;
  logic             tx_mid;

  assign tx_in_ready = (tx_st == S_DATA);

  wire              tx_acc   = tx_in_valid && tx_in_ready;
  wire [15:0]       tx_cin   = tx_in_sop ? 16'hFFFF : tx_crc;
  wire [15:0]       tx_dm    = tx_in_sop ? (tx_in_data & ~ID_MASK) : tx_in_data;
  wire [15:0]       tx_cnext = crc_step(tx_cin, tx_dm);
  wire [CNT_W-1:0]  tx_idx   = tx_in_sop ? '0 : tx_cnt;
  wire              tx_pad   = ~(tx_cnt[0] ^ tx_mid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_st        <= S_DATA;
      tx_crc       <= 16'hFFFF;
      tx_cnt       <= '0;
      tx_mid       <= 1'b0;
      tx_out_valid <= 1'b0;
      tx_out_data  <= '0;
      tx_out_sop   <= 1'b0;
      tx_out_eop   <= 1'b0;
    end else begin
      tx_out_valid <= 1'b0;
      tx_out_sop   <= 1'b0;
      tx_out_eop   <= 1'b0;
      case (tx_st)
        S_DATA: if (tx_acc) begin
          tx_out_valid <= 1'b1;
          tx_out_data  <= tx_in_data;
          tx_out_sop   <= tx_in_sop;
          tx_crc       <= tx_cnext;
          tx_cnt       <= (tx_idx == CNT_MAX) ? tx_idx : tx_idx + 1'b1;
          if (tx_in_sop) tx_mid <= 1'b0;
          if (tx_in_eop)                  tx_st <= S_FIN;
          else if (tx_idx == MID_LAST)    tx_st <= S_MID;
        end
        S_MID: begin
          tx_out_valid <= 1'b1;
          tx_out_data  <= tx_crc;
          tx_crc       <= crc_step(tx_crc, tx_crc);
          tx_mid       <= 1'b1;
          tx_st        <= S_DATA;
        end
        S_FIN: begin
          tx_out_valid <= 1'b1;
          tx_out_data  <= tx_crc;
          tx_out_eop   <= ~tx_pad;
          tx_st        <= tx_pad ? S_PAD : S_DATA;
        end
        default: begin
          tx_out_valid <= 1'b1;
          tx_out_data  <= 16'h0000;
          tx_out_eop   <= 1'b1;
          tx_st        <= S_DATA;
        end
      endcase
    end
  end

  // receive side
  logic [15:0]      rx_crc;
  logic [CNT_W-1:0] rx_cnt;
  logic             rx_midbad;

  wire [15:0]      rx_cin   = rx_sop ? 16'hFFFF : rx_crc;
  wire [15:0]      rx_dm    = rx_sop ? (rx_data & ~ID_MASK) : rx_data;
  wire [15:0]      rx_cnext = crc_step(rx_cin, rx_dm);
  wire [CNT_W-1:0] rx_idx   = rx_sop ? '0 : rx_cnt;
  wire             rx_has_mid = rx_idx > MID_MIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_crc     <= 16'hFFFF;
      rx_cnt     <= '0;
      rx_midbad  <= 1'b0;
      rx_done    <= 1'b0;
      rx_err     <= 1'b0;
      rx_err_pos <= 2'b00;
    end else begin
      rx_done    <= 1'b0;
      rx_err     <= 1'b0;
      rx_err_pos <= 2'b00;
      if (rx_valid) begin
        rx_crc <= rx_cnext;
        rx_cnt <= (rx_idx == CNT_MAX) ? rx_idx : rx_idx + 1'b1;
        if (rx_idx == MID_POS)  rx_midbad <= (rx_cnext != 16'h0000);
        else if (rx_sop)        rx_midbad <= 1'b0;
        if (rx_eop) begin
          rx_done       <= 1'b1;
          rx_err_pos[1] <= (rx_cnext != 16'h0000);
          rx_err_pos[0] <= rx_has_mid && rx_midbad;
          rx_err        <= (rx_cnext != 16'h0000) || (rx_has_mid && rx_midbad);
        end
      end
    end
  end
endmodule

module crc_pkt_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_in_valid,
  input logic        tx_in_ready,
  input logic [15:0] tx_in_data,
  input logic        tx_in_sop,
  input logic        tx_in_eop,
  input logic        tx_out_valid,
  input logic [15:0] tx_out_data,
  input logic        tx_out_sop,
  input logic        tx_out_eop,
  input logic        rx_valid,
  input logic        rx_eop,
  input logic        rx_done,
  input logic        rx_err,
  input logic [1:0]  rx_err_pos
);
  logic [15:0] ob_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ob_cnt <= '0;
    else if (tx_out_valid) ob_cnt <= tx_out_sop ? 16'd1 : ob_cnt + 16'd1;
  end

  // R7
  a_r7_stall_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_valid && tx_in_ready && tx_in_eop |=> !tx_in_ready);
  // R7
  a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_valid && tx_in_ready |=> tx_out_valid && tx_out_data == $past(tx_in_data));
  // R6
  a_r6_even_length: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && tx_out_eop && !tx_out_sop |-> ob_cnt[0]);
  // R8
  a_r8_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_eop |=> rx_done);
  // R8
  a_r8_err_matches_pos: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err == (rx_done && rx_err_pos != 2'b00));
  // R1
  a_r1_crc_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_valid && tx_in_ready && tx_in_eop |=> ##1 tx_out_valid);
endmodule

bind crc_pkt_guard crc_pkt_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
  .tx_in_sop(tx_in_sop), .tx_in_eop(tx_in_eop),
  .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
  .tx_out_sop(tx_out_sop), .tx_out_eop(tx_out_eop),
  .rx_valid(rx_valid), .rx_eop(rx_eop),
  .rx_done(rx_done), .rx_err(rx_err), .rx_err_pos(rx_err_pos)
);

// File: tb/tb_crc_pkt_guard.sv
module tb_crc_pkt_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_in_valid = 1'b0, tx_in_sop = 1'b0, tx_in_eop = 1'b0;
  logic [15:0] tx_in_data = '0;
  logic        tx_in_ready;
  logic        tx_out_valid, tx_out_sop, tx_out_eop;
  logic [15:0] tx_out_data;
  logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic [15:0] rx_data = '0;
  logic        rx_done, rx_err;
  logic [1:0]  rx_err_pos;

  always #5 clk = ~clk;

  crc_pkt_guard dut (.*);

  int total = 0, bad = 0;
  logic [15:0] ed [0:63];
  int ne;
  logic [15:0] gd [0:63];
  logic        gs [0:63];
  logic        ge [0:63];
  int gi = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] bstep(input logic [15:0] c, input logic [15:0] d);
    logic [31:0] v;
    v = {c ^ d, 16'h0000};
    for (int b = 31; b >= 16; b--)
      if (v[b]) v[b-:17] = v[b-:17] ^ 17'h11021;
    return v[15:0];
  endfunction

  function automatic logic [15:0] pat(input int len, input int i, input logic [4:0] id);
    logic [15:0] d;
    d = 16'(i * 16'h03B1) ^ 16'(len * 16'h1111) ^ 16'h5A00;
    if (i == 0) d[15:11] = id;
    return d;
  endfunction

  task automatic build(input int len, input logic [4:0] id);
    logic [15:0] c;
    logic [15:0] d;
    c = 16'hFFFF; ne = 0;
    for (int i = 0; i < len; i++) begin
      d = pat(len, i, id);
      ed[ne] = d; ne++;
      c = bstep(c, (i == 0) ? {5'b0, d[10:0]} : d);
      if (i == 39 && len > 40) begin
        ed[ne] = c; ne++;
        c = bstep(c, c);
      end
    end
    ed[ne] = c; ne++;
    if (ne % 2 == 1) begin ed[ne] = 16'h0000; ne++; end
  endtask

  always @(negedge clk)
    if (tx_out_valid && gi < 64) begin
      gd[gi] = tx_out_data; gs[gi] = tx_out_sop; ge[gi] = tx_out_eop; gi++;
    end

  task automatic tx_run(input int len, input logic [4:0] id);
    int i;
    bit stalled_ok;
    build(len, id);
    gi = 0; i = 0; stalled_ok = 1;
    while (i < len) begin
      @(negedge clk);
      if (tx_in_ready) begin
        tx_in_valid = 1'b1; tx_in_data = pat(len, i, id);
        tx_in_sop = (i == 0); tx_in_eop = (i == len - 1); i++;
      end else tx_in_valid = 1'b0;
    end
    @(negedge clk);
    tx_in_valid = 1'b0; tx_in_sop = 1'b0; tx_in_eop = 1'b0;
    // R7: the trailing CRC is being produced now
    chk(!tx_in_ready, "R7 ready low during insertion", tx_in_ready, 0);
    repeat (6) @(negedge clk);
    chk(gi == ne, (len > 40) ? "R3 beat count" : "R5 beat count", gi, ne);
    for (int j = 0; j < ne && j < gi; j++) begin
      if (len > 40 && j == 40)
        chk(gd[j] == ed[j], "R3 mid CRC value", gd[j], ed[j]);
      else if (j == ne - 1 && ne > len + 1 + ((len > 40) ? 1 : 0))
        chk(gd[j] == 16'h0000, "R6 pad halfword", gd[j], 0);
      else if (j >= len)
        chk(gd[j] == ed[j], (len > 40) ? "R4 trailing CRC" : "R1 trailing CRC", gd[j], ed[j]);
      else if (j == 0)
        chk(gd[j] == ed[j], "R2 header passes unchanged", gd[j], ed[j]);
      else
        chk(gd[j] == ed[j], "R7 data passthrough", gd[j], ed[j]);
      chk(gs[j] == (j == 0), "R6 start marker", gs[j], j == 0);
      chk(ge[j] == (j == ne - 1), "R6 end marker", ge[j], j == ne - 1);
    end
  endtask

  task automatic rx_run(input int k, input logic [15:0] m, input logic [1:0] exp, input string req);
    for (int j = 0; j < ne; j++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = ed[j] ^ ((j == k) ? m : 16'h0000);
      rx_sop = (j == 0); rx_eop = (j == ne - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    chk(rx_done == 1'b1, "R8 done pulse", rx_done, 1);
    chk(rx_err_pos == exp, req, rx_err_pos, exp);
    chk(rx_err == (exp != 2'b00), "R8 error flag", rx_err, exp != 2'b00);
    @(negedge clk);
    chk(rx_done == 1'b0, "R8 done one cycle", rx_done, 0);
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_out_valid == 1'b0, "R10 tx_out_valid", tx_out_valid, 0);
    chk(rx_done == 1'b0, "R10 rx_done", rx_done, 0);
    chk(tx_in_ready == 1'b1, "R10 tx_in_ready", tx_in_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int len = 1; len <= 48; len++) begin
      logic [4:0] id;
      int kl;
      id = 5'(len * 7);
      tx_run(len, id);
      rx_run(-1, 16'h0000, 2'b00, "R8 clean packet");
      rx_run(0, 16'hF800, 2'b00, "R9 identifier ignored");
      rx_run(0, 16'h0001, (len > 40) ? 2'b11 : 2'b10, "R8 error in first halfword");
      kl = (len > 40) ? len : len - 1;
      rx_run(kl, 16'h0100, 2'b10, "R8 error in last data halfword");
      rx_run(len > 40 ? len + 1 : len, 16'h8000, 2'b10, "R8 error in trailing CRC");
      if (len > 40) rx_run(40, 16'h0002, 2'b11, "R8 error in mid CRC");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule